// File: doc/BRIEF.md
# Register Rename and Dispatch Stage

This block is the in-order dispatch stage of an out-of-order core whose register values all live in one merged physical register file. Each cycle it can accept one decoded instruction carrying a source architected register, a destination architected register and a two-bit class. It maps the source through a speculative rename table and takes a fresh physical register for the destination. It also claims a reorder-buffer slot and, when the class needs one, a reservation-station slot. When any of these resources has run out, it raises a stall in the same cycle.

Behind the speculative table sits a retirement table that only retiring instructions update. When a register-writing instruction retires, its entry in the retirement table takes the new mapping, and the physical register it displaced goes back to the free pool. A branch mispredict overwrites the speculative table with the retirement table and empties the reorder buffer and the reservation stations. It then rebuilds the free pool as every physical register that the retirement table does not reference.

Top module: `rename_dispatch`

## Requirements
- R1: After reset, architected register i maps to physical register i in both tables, physical registers NUM_AREG and above are free, and the reorder buffer and reservation stations are empty.
- R2: `src_ptag` equals the speculative mapping of `disp_src` as it stands before this instruction's own destination is renamed, so a source equal to the destination sees the older mapping.
- R3: Class encodings are 0 ALU, 1 load, 2 store and 3 no-op. An ALU or load instruction that dispatches takes the lowest-numbered free physical register and reports it on `dst_ptag`. It reports the mapping it displaces on `old_ptag`.
- R4: A store or no-op takes no physical register and leaves the rename table unchanged, and for them `dst_ptag` and `old_ptag` read 0. Each dispatching instruction still takes a reorder-buffer slot.
- R5: Reorder-buffer slots are handed out in order, and `rob_tag` counts up modulo ROB_DEPTH from 0. A request stalls while ROB_DEPTH instructions are outstanding, and a retire in that same cycle does not lift the stall.
- R6: ALU, load and store instructions each hold a reservation-station slot until a `rs_done` pulse releases one. No-ops use none. An instruction that needs a slot stalls while RS_DEPTH slots are held.
- R7: With the free pool empty, ALU and load instructions stall, but a store or no-op may still dispatch.
- R8: On `retire_valid` with a non-empty reorder buffer, the oldest entry retires. If it writes a register, the retirement table takes its new mapping, and the displaced register becomes allocatable from the next cycle.
- R9: On `mispredict`, the speculative table becomes a copy of the retirement table. The free pool becomes every register that the retirement table does not reference, both occupancy counts go to zero, and slot numbering restarts at 0. Any request in that cycle stalls, and a retire in that cycle is ignored.
- R10: `disp_stall` is combinational, is low whenever `disp_valid` is low, and a stalled request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A decoded instruction is offered |
| disp_src | input | AW | Source architected register |
| disp_dst | input | AW | Destination architected register |
| disp_class | input | 2 | 0 ALU, 1 load, 2 store, 3 no-op |
| rs_done | input | 1 | One reservation-station slot finished executing |
| retire_valid | input | 1 | Retire the oldest reorder-buffer entry |
| mispredict | input | 1 | Restore state from the retirement table |
| disp_stall | output | 1 | Offered instruction cannot dispatch this cycle |
| src_ptag | output | PW | Physical register for the source |
| dst_ptag | output | PW | Newly allocated physical register |
| old_ptag | output | PW | Physical register previously mapped to the destination |
| rob_tag | output | IW | Reorder-buffer slot given to the instruction |

## Verification
A behavioural model with queues and integers predicts every output each cycle. It runs against directed sequences and then a long random mix. A stream of no-ops fills the reorder buffer alone, and a stream of stores fills the reservation stations alone. ALU writes with steady slot release then drain the free pool alone, with a store dispatching past the empty pool. Together these separate the three stall causes. Source-equals-destination pairs, retires that coincide with dispatch and back-to-back mispredicts expose ordering mistakes in table reads, in when a freed register becomes visible, and in how the free pool is rebuilt.

// File: rtl/rd_pkg.sv
package rd_pkg;
   typedef enum logic [1:0] {
      CLS_ALU   = 2'd0,
      CLS_LOAD  = 2'd1,
      CLS_STORE = 2'd2,
      CLS_NOP   = 2'd3
   } op_class_e;
endpackage

// File: rtl/rd_free_list.sv
module rd_free_list #(
   parameter int NUM_PREG = 9,
   parameter int NUM_AREG = 4,
   parameter int PW       = $clog2(NUM_PREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc,
   input  logic                rel,
   input  logic [PW-1:0]       rel_idx,
   input  logic                flush,
   input  logic [NUM_PREG-1:0] flush_used,
   output logic                has_free,
   output logic [PW-1:0]       alloc_idx,
   output logic [NUM_PREG-1:0] free_vec
);
   logic [NUM_PREG-1:0] take_mask, give_mask;

   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      alloc_idx = '0;
      has_free  = 1'b0;
      for (int i = NUM_PREG - 1; i >= 0; i--) begin
         if (free_vec[i]) begin
            alloc_idx = PW'(i);
            has_free  = 1'b1;
         end
      end
   end

   always_comb begin
      take_mask = '0;
      give_mask = '0;
      if (alloc) take_mask[alloc_idx] = 1'b1;
      if (rel)   give_mask[rel_idx]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PREG; i++) free_vec[i] <= (i >= NUM_AREG);
      end else if (flush) begin
         free_vec <= ~flush_used;
      end else begin
         free_vec <= (free_vec & ~take_mask) | give_mask;
      end
   end
endmodule

// File: rtl/rd_map_tables.sv
module rd_map_tables #(
   parameter int NUM_AREG = 4,
   parameter int NUM_PREG = 9,
   parameter int AW       = (NUM_AREG > 1) ? $clog2(NUM_AREG) : 1,
   parameter int PW       = $clog2(NUM_PREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       src,
   input  logic [AW-1:0]       dst,
   output logic [PW-1:0]       src_tag,
   output logic [PW-1:0]       old_tag,
   input  logic                spec_we,
   input  logic [PW-1:0]       spec_tag,
   input  logic                ret_we,
   input  logic [AW-1:0]       ret_areg,
   input  logic [PW-1:0]       ret_tag,
   input  logic                flush,
   output logic [NUM_PREG-1:0] used_vec
);
   logic [PW-1:0] spec_map [NUM_AREG];
   logic [PW-1:0] arch_map [NUM_AREG];

   assign src_tag = spec_map[src];
   assign old_tag = spec_map[dst];

   always_comb begin
      used_vec = '0;
      for (int a = 0; a < NUM_AREG; a++) used_vec[arch_map[a]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_AREG; a++) begin
            spec_map[a] <= PW'(a);
            arch_map[a] <= PW'(a);
         end
      end else if (flush) begin
         for (int a = 0; a < NUM_AREG; a++) spec_map[a] <= arch_map[a];
      end else begin
         if (spec_we) spec_map[dst]      <= spec_tag;
         if (ret_we)  arch_map[ret_areg] <= ret_tag;
      end
   end
endmodule

// File: rtl/rd_rob.sv
module rd_rob #(
   parameter int DEPTH = 6,
   parameter int AW    = 2,
   parameter int PW    = 4,
   parameter int IW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          push_wr,
   input  logic [AW-1:0] push_areg,
   input  logic [PW-1:0] push_new,
   input  logic [PW-1:0] push_old,
   input  logic          pop,
   output logic          head_wr,
   output logic [AW-1:0] head_areg,
   output logic [PW-1:0] head_new,
   output logic [PW-1:0] head_old,
   output logic [IW-1:0] tail_idx,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic          ent_wr   [DEPTH];
   logic [AW-1:0] ent_areg [DEPTH];
   logic [PW-1:0] ent_new  [DEPTH];
   logic [PW-1:0] ent_old  [DEPTH];
   logic [IW-1:0] head_idx;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
      return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign head_wr   = ent_wr[head_idx];
   assign head_areg = ent_areg[head_idx];
   assign head_new  = ent_new[head_idx];
   assign head_old  = ent_old[head_idx];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_idx <= '0;
         tail_idx <= '0;
         count    <= '0;
      end else begin
         if (push) tail_idx <= bump(tail_idx);
         if (pop)  head_idx <= bump(head_idx);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         ent_wr[tail_idx]   <= push_wr;
         ent_areg[tail_idx] <= push_areg;
         ent_new[tail_idx]  <= push_new;
         ent_old[tail_idx]  <= push_old;
      end
   end
endmodule

// File: rtl/rename_dispatch.sv
module rename_dispatch #(
   parameter int NUM_AREG  = 4,
   parameter int NUM_PREG  = 9,
   parameter int ROB_DEPTH = 6,
   parameter int RS_DEPTH  = 3,
   parameter int AW        = (NUM_AREG > 1) ? $clog2(NUM_AREG) : 1,
   parameter int PW        = $clog2(NUM_PREG),
   parameter int IW        = $clog2(ROB_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_valid,
   input  logic [AW-1:0] disp_src,
   input  logic [AW-1:0] disp_dst,
   input  logic [1:0]    disp_class,
   input  logic          rs_done,
   input  logic          retire_valid,
   input  logic          mispredict,
   output logic          disp_stall,
   output logic [PW-1:0] src_ptag,
   output logic [PW-1:0] dst_ptag,
   output logic [PW-1:0] old_ptag,
   output logic [IW-1:0] rob_tag
);
   import rd_pkg::*;

   localparam int CW  = $clog2(ROB_DEPTH + 1);
   localparam int SCW = $clog2(RS_DEPTH + 1);

   if (NUM_PREG <= NUM_AREG) begin : g_bad_preg_low
      $error("NUM_PREG must exceed NUM_AREG");
   end
   if (NUM_PREG > NUM_AREG + ROB_DEPTH) begin : g_bad_preg_high
      $error("NUM_PREG beyond NUM_AREG+ROB_DEPTH cannot be used");
   end
   if (ROB_DEPTH < 2 || RS_DEPTH < 1) begin : g_bad_depth
      $error("ROB_DEPTH must be >= 2 and RS_DEPTH >= 1");
   end

   op_class_e      cls;
   logic           writes, needs_rs, fire, retire_fire;
   logic           has_free, rob_full, rob_empty, rs_full;
   logic [PW-1:0]  alloc_idx, map_src, map_old;
   logic [NUM_PREG-1:0] free_vec, used_vec;
   logic [CW-1:0]  rob_count;
   logic [SCW-1:0] rs_count;
   logic           head_wr;
   logic [AW-1:0]  head_areg;
   logic [PW-1:0]  head_new, head_old;

   assign cls         = op_class_e'(disp_class);
   assign writes      = (cls == CLS_ALU) || (cls == CLS_LOAD);
   assign needs_rs    = (cls != CLS_NOP);
   assign rs_full     = (rs_count == SCW'(RS_DEPTH));
   assign disp_stall  = disp_valid & (mispredict | rob_full | (needs_rs & rs_full)
                                      | (writes & ~has_free));
   assign fire        = disp_valid & ~disp_stall;
   assign retire_fire = retire_valid & ~rob_empty & ~mispredict;

   assign src_ptag = map_src;
   assign dst_ptag = writes ? alloc_idx : '0;
   assign old_ptag = writes ? map_old : '0;

   rd_map_tables #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .AW(AW), .PW(PW)) u_maps (
      .clk(clk), .rst_n(rst_n),
      .src(disp_src), .dst(disp_dst), .src_tag(map_src), .old_tag(map_old),
      .spec_we(fire & writes), .spec_tag(alloc_idx),
      .ret_we(retire_fire & head_wr), .ret_areg(head_areg), .ret_tag(head_new),
      .flush(mispredict), .used_vec(used_vec)
   );

   rd_free_list #(.NUM_PREG(NUM_PREG), .NUM_AREG(NUM_AREG), .PW(PW)) u_free (
      .clk(clk), .rst_n(rst_n),
      .alloc(fire & writes),
      .rel(retire_fire & head_wr), .rel_idx(head_old),
      .flush(mispredict), .flush_used(used_vec),
      .has_free(has_free), .alloc_idx(alloc_idx), .free_vec(free_vec)
   );

   rd_rob #(.DEPTH(ROB_DEPTH), .AW(AW), .PW(PW), .IW(IW), .CW(CW)) u_rob (
      .clk(clk), .rst_n(rst_n), .flush(mispredict),
      .push(fire), .push_wr(writes), .push_areg(disp_dst),
      .push_new(alloc_idx), .push_old(map_old),
      .pop(retire_fire),
      .head_wr(head_wr), .head_areg(head_areg), .head_new(head_new), .head_old(head_old),
      .tail_idx(rob_tag), .count(rob_count), .full(rob_full), .empty(rob_empty)
   );

   // reservation-station occupancy: a release with nothing held is dropped
   always_ff @(posedge clk) begin
      if (!rst_n || mispredict) begin
         rs_count <= '0;
      end else begin
         rs_count <= rs_count + SCW'(fire & needs_rs) - SCW'(rs_done && rs_count != '0);
      end
   end
endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
   parameter int NUM_AREG  = 4,
   parameter int NUM_PREG  = 9,
   parameter int ROB_DEPTH = 6,
   parameter int RS_DEPTH  = 3
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               disp_valid,
   input logic [1:0]                         disp_class,
   input logic                               disp_stall,
   input logic                               retire_valid,
   input logic                               mispredict,
   input logic [$clog2(ROB_DEPTH+1)-1:0]     rob_count,
   input logic [$clog2(RS_DEPTH+1)-1:0]      rs_count,
   input logic [NUM_PREG-1:0]                free_vec
);
   p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_valid |-> !disp_stall);

   p_rob_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rob_count) <= ROB_DEPTH);

   p_rob_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && int'(rob_count) == ROB_DEPTH) |-> disp_stall);

   p_rs_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_class != 2'd3 && int'(rs_count) == RS_DEPTH) |-> disp_stall);

   p_no_free_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_class[1] == 1'b0 && free_vec == '0) |-> disp_stall);

   p_retire_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !mispredict && rob_count != '0 && !(disp_valid && !disp_stall))
      |=> int'(rob_count) == int'($past(rob_count)) - 1);

   p_flush_rebuild_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> (rob_count == '0 && rs_count == '0
                      && $countones(free_vec) == NUM_PREG - NUM_AREG));
endmodule

bind rename_dispatch rd_checker #(
   .NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .ROB_DEPTH(ROB_DEPTH), .RS_DEPTH(RS_DEPTH)
) u_rd_checker (
   .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_class(disp_class),
   .disp_stall(disp_stall), .retire_valid(retire_valid), .mispredict(mispredict),
   .rob_count(rob_count), .rs_count(rs_count), .free_vec(free_vec)
);

// File: tb/rename_dispatch_tb_top.sv
module rename_dispatch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NA = 4, NP = 9, RD = 6, RSD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       disp_valid = 1'b0, rs_done = 1'b0, retire_valid = 1'b0, mispredict = 1'b0;
   logic [1:0] disp_src = '0, disp_dst = '0, disp_class = '0;
   logic       disp_stall;
   logic [3:0] src_ptag, dst_ptag, old_ptag;
   logic [2:0] rob_tag;

   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { bit wr; int a; int nw; int old; } rob_ent_t;
   int       m_rat [NA];
   int       m_rrat[NA];
   bit       m_free[NP];
   rob_ent_t m_rob [$];
   int       m_rs, m_tail;

   always #(CLK_PERIOD/2) clk = ~clk;

   rename_dispatch #(.NUM_AREG(NA), .NUM_PREG(NP), .ROB_DEPTH(RD), .RS_DEPTH(RSD)) dut_i (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_src(disp_src),
      .disp_dst(disp_dst), .disp_class(disp_class), .rs_done(rs_done),
      .retire_valid(retire_valid), .mispredict(mispredict), .disp_stall(disp_stall),
      .src_ptag(src_ptag), .dst_ptag(dst_ptag), .old_ptag(old_ptag), .rob_tag(rob_tag)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int a = 0; a < NA; a++) begin m_rat[a] = a; m_rrat[a] = a; end
      for (int p = 0; p < NP; p++) m_free[p] = (p >= NA);
      m_rob.delete();
      m_rs = 0;
      m_tail = 0;
   endtask

   // one cycle: drive, compare before the edge, advance model, wait for edge
   task automatic step(bit v, int s, int d, int c, bit rd, bit ret, bit mp, string req);
      bit wr, nrs, stl, used[NP];
      int alloc, freed;
      @(negedge clk);
      disp_valid = v; disp_src = 2'(s); disp_dst = 2'(d); disp_class = 2'(c);
      rs_done = rd; retire_valid = ret; mispredict = mp;
      #1;
      wr = (c == 0 || c == 1);
      nrs = (c != 3);
      alloc = -1;
      for (int p = NP - 1; p >= 0; p--) if (m_free[p]) alloc = p;
      stl = v && (mp || m_rob.size() == RD || (nrs && m_rs == RSD) || (wr && alloc < 0));
      check({req, " R10"}, "disp_stall", int'(disp_stall), int'(stl));
      if (v && !stl) begin
         check({req, " R2"}, "src_ptag", int'(src_ptag), m_rat[s]);
         check({req, " R3 R4"}, "dst_ptag", int'(dst_ptag), wr ? alloc : 0);
         check({req, " R3 R4"}, "old_ptag", int'(old_ptag), wr ? m_rat[d] : 0);
         check({req, " R5"}, "rob_tag", int'(rob_tag), m_tail);
      end
      if (mp) begin
         for (int p = 0; p < NP; p++) used[p] = 0;
         for (int a = 0; a < NA; a++) begin m_rat[a] = m_rrat[a]; used[m_rrat[a]] = 1; end
         for (int p = 0; p < NP; p++) m_free[p] = !used[p];
         m_rob.delete();
         m_rs = 0;
         m_tail = 0;
      end else begin
         freed = -1;
         if (ret && m_rob.size() > 0) begin
            rob_ent_t e = m_rob.pop_front();
            if (e.wr) begin m_rrat[e.a] = e.nw; freed = e.old; end
         end
         if (rd && m_rs > 0) m_rs--;
         if (v && !stl) begin
            rob_ent_t n;
            n.wr = wr; n.a = d; n.nw = wr ? alloc : 0; n.old = m_rat[d];
            if (wr) begin m_rat[d] = alloc; m_free[alloc] = 0; end
            m_rob.push_back(n);
            m_tail = (m_tail + 1) % RD;
            if (nrs) m_rs++;
         end
         if (freed >= 0) m_free[freed] = 1;
      end
      @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: identity mappings, first free register is NA
      step(0, 0, 0, 0, 0, 0, 0, "R1");
      step(1, 2, 3, 0, 0, 0, 0, "R1");
      check("R1", "first dst", int'(m_rat[3]), NA);
      // R2: source equal to destination sees prior mapping
      step(1, 3, 3, 1, 1, 0, 0, "R2");
      step(1, 3, 0, 0, 1, 0, 0, "R2");
      // R4: store and no-op take no register
      step(1, 1, 2, 2, 1, 0, 0, "R4");
      step(1, 1, 2, 3, 1, 0, 0, "R4");
      // R5: fill reorder buffer, retire in same cycle does not help
      step(1, 0, 0, 3, 1, 0, 0, "R5");
      step(1, 0, 0, 3, 0, 1, 0, "R5");
      step(1, 0, 0, 3, 0, 1, 0, "R5");
      // R8: drain with retires, freed register reused later
      for (int i = 0; i < RD; i++) step(0, 0, 0, 0, 1, 1, 0, "R8");
      step(1, 1, 1, 0, 1, 0, 0, "R8");
      // R9: recover
      step(1, 0, 1, 0, 0, 0, 1, "R9");
      step(1, 1, 2, 0, 0, 0, 0, "R9");
      step(0, 0, 0, 0, 0, 0, 1, "R9");
      // R6: reservation stations fill with stores, no-op passes
      for (int i = 0; i < 4; i++) step(1, 0, 0, 2, 0, 0, 0, "R6");
      step(1, 0, 1, 0, 0, 0, 0, "R6");
      step(1, 0, 0, 3, 0, 0, 0, "R6");
      step(1, 0, 0, 2, 1, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, 1, "R9");
      // R7: drain free pool with ALU writes, store still dispatches
      for (int i = 0; i < NP - NA + 1; i++) step(1, i % NA, i % NA, 0, 1, 0, 0, "R7");
      step(1, 2, 0, 2, 1, 0, 0, "R7");
      step(1, 1, 1, 1, 1, 1, 0, "R7");
      step(1, 1, 1, 1, 1, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 1, "R9");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r = int'($urandom_range(0, 99));
         step(r < 70, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
              $urandom_range(0, 2) == 0, r >= 97, "R3");
      end
      step(0, 0, 0, 0, 0, 0, 0, "R10");
      finish_run();
   end
endmodule